// File: doc/BRIEF.md
# Parallel Three-Tap Half-Band Decimate-by-Two Stage

This block is one low-pass, decimate-by-two stage for a wideband receive path. The sample rate there is far above the clock rate, so every clock brings a bus of `LANES` signed samples, lane 0 the earliest in time. Every clock that carries valid data produces `LANES/2` filtered samples. The filter is a symmetric three-tap half-band kernel in polyphase form. Only the output phases that survive decimation are built, so the odd-centred results are never computed.

Every output is formed by one three-input adder over sign-extended samples that are shifted by parameter amounts. No multiplier is used. The default weights are 1, 2, 1. The outer and centre shifts are parameters, so a second cascaded stage can reuse this block with other power-of-two weights. The output lanes are wider than the input by the coefficient growth, and rescaling is left to the stage that follows.

Output lane k is centred on input lane 2k. Its lower neighbour for lane 0 is the last lane of the previous accepted beat, which a one-sample history register keeps. The results are registered once, and the output strobe follows the input strobe by one clock.

Top module: `hb_decim2`

## Requirements
- R1: While `rst` is high at a rising clock edge, the next cycle shows `outValid` low and all output lanes at zero.
- R2: Lanes are packed so that lane j occupies bits [j*W +: W] of its bus. Output lane k equals x[2k-1]*2^SIDE_SH + x[2k]*2^MID_SH + x[2k+1]*2^SIDE_SH, where x is the input lane value as signed. The defaults give weights 1, 2, 1.
- R3: For output lane 0, the lower neighbour x[-1] is input lane LANES-1 of the most recent beat that was accepted with `inValid` high.
- R4: A beat accepted at an edge where `inValid` is high yields `outValid` high and its results on `outData` in the following cycle. An edge where `inValid` is low yields `outValid` low.
- R5: While `inValid` is low, `inData` is ignored. `outData` keeps its value, and the history sample also stays unchanged, which shows in lane 0 of the next valid beat.
- R6: The output lane width is IN_W plus the growth bits, which is 8 bits for the defaults. All-minimum input (-32) gives exactly -128, and all-maximum input (31) gives exactly 124, with no wrap.
- R7: Reset clears the history sample, so the first beat after reset uses zero as the neighbour of output lane 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Marks `inData` as a valid beat |
| inData | input | LANES*IN_W | Input samples, signed, lane 0 earliest |
| outValid | output | 1 | Marks `outData` as new results |
| outData | output | LANES/2*OUT_W | Decimated samples, signed, OUT_W = IN_W + growth |

## Verification
An impulse placed in the last lane shows, on the next beat, whether the history sample reaches lane 0. Impulses in even and odd lanes also reveal the centre and side weights separately. A ramp checks the ordering of the lanes. Alternating signs at the highest rate must cancel to zero in every lane, which separates a correct kernel from one that has a wrong side or centre weight. DC at the maximum and minimum input values probes the growth bits for wrap. Random beats mixed with idle gaps that carry garbage data, and a reset in the middle of the run, check that the data is held and the history is cleared.

// File: rtl/hb_pkg.sv
package hb_pkg;

  // Strobes from the control unit to the datapath.
  typedef struct packed {
    logic clear;     // synchronous clear of all state
    logic loadHist;  // capture the last input lane as history
    logic loadOut;   // capture the new output lanes
  } hbStrobes_t;

  // Extra output bits that the weight sum 2*2^side + 2^mid needs.
  function automatic int growBits(input int sideShift, input int midShift);
    return $clog2((2 << sideShift) + (1 << midShift));
  endfunction

endpackage

// File: rtl/hb_ctrl.sv
module hb_ctrl
  import hb_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       inValid,
  output hbStrobes_t strobes,
  output logic       outValid
);

  always_comb begin
    strobes.clear    = rst;
    strobes.loadHist = inValid && !rst;
    strobes.loadOut  = inValid && !rst;
  end

  always_ff @(posedge clk) begin
    if (rst) outValid <= 1'b0;
    else     outValid <= inValid;
  end

  // R4: the output strobe trails the accepted input by one clock
  assert_valid_rise_R4: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);
  assert_valid_drop_R4: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid);

endmodule

// File: rtl/hb_tap.sv
module hb_tap #(
  parameter int IN_W    = 6,
  parameter int OUT_W   = 8,
  parameter int SIDE_SH = 0,
  parameter int MID_SH  = 1
) (
  input  logic signed [IN_W-1:0]  prevS,
  input  logic signed [IN_W-1:0]  midS,
  input  logic signed [IN_W-1:0]  nextS,
  output logic signed [OUT_W-1:0] sum
);

  localparam int WIDE_W = OUT_W + 1;

  logic signed [WIDE_W-1:0] prevW, midW, nextW, sumWide;

  always_comb begin
    prevW   = WIDE_W'(prevS);
    midW    = WIDE_W'(midS);
    nextW   = WIDE_W'(nextS);
    // one ternary addition of shifted operands, no multiplier
    sumWide = (prevW <<< SIDE_SH) + (midW <<< MID_SH) + (nextW <<< SIDE_SH);
    sum     = sumWide[OUT_W-1:0];
  end

  // R6: the growth bits hold every sum, so dropping the top bit loses nothing
  always_comb begin
    assert_no_overflow_R6: assert (sumWide[WIDE_W-1] == sumWide[WIDE_W-2]);
  end

endmodule

// File: rtl/hb_datapath.sv
module hb_datapath
  import hb_pkg::*;
#(
  parameter int LANES   = 8,
  parameter int IN_W    = 6,
  parameter int OUT_W   = 8,
  parameter int SIDE_SH = 0,
  parameter int MID_SH  = 1
) (
  input  logic                         clk,
  input  hbStrobes_t                   strobes,
  input  logic [LANES*IN_W-1:0]        inData,
  output logic [(LANES/2)*OUT_W-1:0]   outData
);

  localparam int HALF = LANES / 2;

  logic [IN_W-1:0]           histQ;
  logic [HALF*OUT_W-1:0]     sumAll;

  for (genvar k = 0; k < HALF; k++) begin : g_phase
    logic [IN_W-1:0] prevLane;
    if (k == 0) begin : g_edge
      assign prevLane = histQ;
    end else begin : g_inner
      assign prevLane = inData[(2*k-1)*IN_W +: IN_W];
    end

    hb_tap #(
      .IN_W   (IN_W),
      .OUT_W  (OUT_W),
      .SIDE_SH(SIDE_SH),
      .MID_SH (MID_SH)
    ) i_tap (
      .prevS(prevLane),
      .midS (inData[(2*k)*IN_W +: IN_W]),
      .nextS(inData[(2*k+1)*IN_W +: IN_W]),
      .sum  (sumAll[k*OUT_W +: OUT_W])
    );
  end

  always_ff @(posedge clk) begin
    if (strobes.clear) begin
      histQ   <= '0;
      outData <= '0;
    end else begin
      if (strobes.loadHist) histQ   <= inData[(LANES-1)*IN_W +: IN_W];
      if (strobes.loadOut)  outData <= sumAll;
    end
  end

  // R1: clear empties the output lanes
  assert_clear_R1: assert property (@(posedge clk)
    strobes.clear |=> (outData == '0));
  // R7: clear empties the history sample
  assert_hist_zero_R7: assert property (@(posedge clk)
    strobes.clear |=> (histQ == '0));
  // R3: history follows the last lane of an accepted beat
  assert_hist_track_R3: assert property (@(posedge clk) disable iff (strobes.clear)
    strobes.loadHist |=> (histQ == $past(inData[(LANES-1)*IN_W +: IN_W])));
  // R5: idle cycles leave both history and outputs alone
  assert_hold_hist_R5: assert property (@(posedge clk) disable iff (strobes.clear)
    !strobes.loadHist |=> $stable(histQ));
  assert_hold_out_R5: assert property (@(posedge clk) disable iff (strobes.clear)
    !strobes.loadOut |=> $stable(outData));

endmodule

// File: rtl/hb_decim2.sv
module hb_decim2
  import hb_pkg::*;
#(
  parameter  int LANES   = 8,
  parameter  int IN_W    = 6,
  parameter  int SIDE_SH = 0,
  parameter  int MID_SH  = 1,
  localparam int OUT_W   = IN_W + growBits(SIDE_SH, MID_SH),
  localparam int HALF    = LANES / 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  inValid,
  input  logic [LANES*IN_W-1:0] inData,
  output logic                  outValid,
  output logic [HALF*OUT_W-1:0] outData
);

  hbStrobes_t strobes;

  hb_ctrl i_ctrl (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .strobes (strobes),
    .outValid(outValid)
  );

  hb_datapath #(
    .LANES  (LANES),
    .IN_W   (IN_W),
    .OUT_W  (OUT_W),
    .SIDE_SH(SIDE_SH),
    .MID_SH (MID_SH)
  ) i_datapath (
    .clk    (clk),
    .strobes(strobes),
    .inData (inData),
    .outData(outData)
  );

endmodule

// File: tb/test_hb_decim2.sv
module test_hb_decim2;

  localparam int LANES = 8;
  localparam int IW    = 6;
  localparam int OW    = 8;
  localparam int HALF  = LANES / 2;

  typedef struct {
    logic [HALF*OW-1:0] vec;
    string              tag;
  } item_t;

  logic                  clk = 1'b0;
  logic                  rst = 1'b1;
  logic                  inValid = 1'b0;
  logic [LANES*IW-1:0]   inData = '0;
  logic                  outValid;
  logic [HALF*OW-1:0]    outData;

  item_t                 sb[$];
  int                    checks = 0;
  int                    fails  = 0;
  logic signed [IW-1:0]  histModel = '0;
  logic [HALF*OW-1:0]    lastOut = '0;
  bit                    done = 1'b0;

  always #2 clk = ~clk;

  hb_decim2 i_hb_decim2 (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .inData  (inData),
    .outValid(outValid),
    .outData (outData)
  );

  function automatic int laneOf(input logic [LANES*IW-1:0] d, input int j);
    logic signed [IW-1:0] v;
    v = d[j*IW +: IW];
    return int'(v);
  endfunction

  // R2, R3: weights 1, 2, 1 centred on even lanes, history below lane 0
  function automatic logic [HALF*OW-1:0] model(input logic [LANES*IW-1:0] d,
                                               input logic signed [IW-1:0] h);
    logic [HALF*OW-1:0] r;
    for (int k = 0; k < HALF; k++) begin
      int p, s;
      p = (k == 0) ? int'(h) : laneOf(d, 2*k-1);
      s = p + 2*laneOf(d, 2*k) + laneOf(d, 2*k+1);
      r[k*OW +: OW] = OW'(s);
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [HALF*OW-1:0] act,
                       input logic [HALF*OW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic sendBeat(input logic [LANES*IW-1:0] d, input string tag);
    item_t it;
    @(negedge clk);
    inValid = 1'b1;
    inData  = d;
    it.vec  = model(d, histModel);
    it.tag  = tag;
    sb.push_back(it);
    histModel = d[(LANES-1)*IW +: IW];
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b0;
      inData  = {$urandom, $urandom};  // garbage that must be ignored (R5)
    end
  endtask

  task automatic doReset();
    idle(2);
    @(negedge clk);
    rst = 1'b1;
    inValid = 1'b0;
    histModel = '0;
    @(negedge clk);
    rst = 1'b0;
  endtask

  function automatic logic [LANES*IW-1:0] fill(input int v);
    logic [LANES*IW-1:0] d;
    for (int j = 0; j < LANES; j++) d[j*IW +: IW] = IW'(v);
    return d;
  endfunction

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  // monitor: sample one time unit after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (done) break;
      if (rst) begin
        check(outValid == 1'b0 && outData == '0, "R1 reset state", outData, '0);
        lastOut = '0;
      end else if (outValid) begin
        if (sb.size() == 0) begin
          check(1'b0, "R4 unexpected outValid", outData, lastOut);
        end else begin
          item_t it;
          it = sb.pop_front();
          check(outData == it.vec, it.tag, outData, it.vec);
        end
        lastOut = outData;
      end else begin
        check(outData == lastOut, "R5 hold while idle", outData, lastOut);
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [LANES*IW-1:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R7: first beat after reset sees a zero neighbour
    sendBeat(fill(5), "R7 zero history after reset");
    // R3: impulse in last lane must reach lane 0 of the next beat
    d = '0; d[(LANES-1)*IW +: IW] = IW'(9);
    sendBeat(d, "R2 impulse in last lane");
    sendBeat('0, "R3 history into lane 0");
    // R2: impulses in even and odd lanes
    d = '0; d[2*IW +: IW] = IW'(7);
    sendBeat(d, "R2 centre weight");
    d = '0; d[3*IW +: IW] = IW'(-5);
    sendBeat(d, "R2 side weight");
    // R2: ramp checks lane ordering
    for (int j = 0; j < LANES; j++) d[j*IW +: IW] = IW'(j - 3);
    sendBeat(d, "R2 ramp");
    // R2: alternating signs cancel
    for (int j = 0; j < LANES; j++) d[j*IW +: IW] = (j % 2 == 0) ? IW'(11) : IW'(-11);
    sendBeat(d, "R2 alternating");
    sendBeat(d, "R2 alternating steady");
    // R6: extremes
    sendBeat(fill(-32), "R6 minimum input");
    sendBeat(fill(-32), "R6 minimum steady");
    sendBeat(fill(31), "R6 maximum input");
    sendBeat(fill(31), "R6 maximum steady");
    // R5: idle gap with garbage, history held across it
    d = '0; d[(LANES-1)*IW +: IW] = IW'(-17);
    sendBeat(d, "R2 last lane before gap");
    idle(4);
    sendBeat('0, "R5 history held across gap");
    // random beats with random gaps
    for (int i = 0; i < 40; i++) begin
      sendBeat({$urandom, $urandom}, "R2 random");
      if ($urandom_range(0, 2) == 0) idle($urandom_range(1, 3));
    end
    // R7: reset mid-stream clears the history
    d = fill(-20);
    sendBeat(d, "R2 before reset");
    doReset();
    sendBeat('0, "R7 history cleared by reset");
    idle(4);

    // R4: every accepted beat produced exactly one result
    checks++;
    if (sb.size() != 0) begin
      fails++;
      $display("FAIL R4: actual %0d pending expected 0", sb.size());
    end
    done = 1'b1;
    summary();
    $finish;
  end

endmodule